// File: doc/BRIEF.md
# External Interrupt Pin Detector

This block turns one or two asynchronous, active-low interrupt pins into interrupt requests for a priority controller. Each pin passes through a two-flop synchronizer. The synchronized value is then captured on a shared sample strobe, so edge detection compares successive samples rather than successive clock cycles. A per-pin mode bit selects how the request is formed. In level mode the request is simply the inverse of the latest sample. In edge mode a sticky flag is set when a high sample is followed by a low one, and the flag holds until a hardware acknowledge or a software clear removes it.

A wake-up output tells the clock and power control that an enabled request is present while the device is idle or powered down. After reset the detector does not arm edge detection until the synchronizer has settled and one valid sample has been taken. As a result, a pin that is already held low when reset ends never produces a request by itself.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset is released with all pins high, `irq_req` is all zero and `wake` is 0.
- R2: With `edge_mode[i]`=0 (level mode), `irq_req[i]` equals the inverse of the most recent sample of pin i and changes only in the cycle after a `sample_tick`. A flag stored in edge mode is discarded while the pin is in level mode.
- R3: With `edge_mode[i]`=1 (edge mode), a sample of pin i that reads low right after a sample that read high sets the flag, and `irq_req[i]` is 1 in the cycle after that tick. A pin level present before clock edge k is first seen by a tick at edge k+2.
- R4: In edge mode a set flag stays set while neither `ack[i]` nor `sw_clr[i]` is high, including after the pin returns high.
- R5: In edge mode, a high `ack[i]` or `sw_clr[i]` on a clock edge with no new falling sample clears the flag, and `irq_req[i]` is 0 from the next cycle on.
- R6: When a new falling sample and a clear (`ack[i]` or `sw_clr[i]`) fall on the same edge, the flag ends up set.
- R7: A pin held low through reset gives no edge-mode request. Edge detection is armed only by the first tick taken at least two clock edges after reset, and that tick only records the sample.
- R8: `wake` is 1 exactly when `low_power` is 1 and some pin has both `irq_req[i]` and `irq_en[i]` high.
- R9: The pin is sampled only on edges where `sample_tick` is 1. A low pulse that no tick observes creates no request.
- R10: Each pin's request depends only on its own pin, mode, acknowledge and clear inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | Sample strobe shared by all pins |
| pin_n | input | NUM_PINS | Raw active-low interrupt pins |
| edge_mode | input | NUM_PINS | Per-pin mode: 0 level, 1 falling edge |
| irq_en | input | NUM_PINS | Per-pin interrupt enable for wake-up |
| ack | input | NUM_PINS | Hardware acknowledge pulse, clears edge flag |
| sw_clr | input | NUM_PINS | Software clear pulse, clears edge flag |
| low_power | input | 1 | Device is idle or powered down |
| irq_req | output | NUM_PINS | Interrupt request to priority logic |
| wake | output | 1 | Wake-up request |

## Verification
The functions that can collide are the setting of the sticky flag by a new falling sample and the clearing of that flag by an acknowledge or software clear. The bench provokes this directly: it clears a set flag, settles a low pin in the synchronizer without a tick, and then drives the tick and `ack` on the same edge. It judges the result by requiring `irq_req` to read 1 afterwards. The random phase drives acknowledges, clears, ticks and pin changes together, and compares every cycle against a bench model that applies the "set wins" rule.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
   typedef enum logic {
      TRIG_LEVEL = 1'b0,
      TRIG_FALL  = 1'b1
   } trig_mode_e;

   localparam int unsigned MIN_SYNC_STAGES = 2;
   localparam int unsigned MAX_PINS        = 2;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ext_irq_arm.sv
module ext_irq_arm #(
   parameter int unsigned SETTLE = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sample_tick,
   output logic armed
);
   localparam int unsigned CW = $clog2(SETTLE + 1);
   localparam logic [CW-1:0] SETTLE_C = CW'(SETTLE);

   logic [CW-1:0] settle_cnt;
   logic          settled;

   assign settled = (settle_cnt == SETTLE_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         settle_cnt <= '0;
         armed      <= 1'b0;
      end else begin
         if (!settled)               settle_cnt <= settle_cnt + 1'b1;
         if (settled && sample_tick) armed      <= 1'b1;
      end
   end
endmodule

// File: rtl/ext_irq_pin.sv
module ext_irq_pin
   import ext_irq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sync_pin,
   input  logic sample_tick,
   input  logic armed,
   input  logic edge_mode,
   input  logic clr,
   output logic irq_req
);
   logic       last_smp;
   logic       fall_seen;
   logic       flag_q;
   trig_mode_e mode;

   assign mode      = trig_mode_e'(edge_mode);
   assign fall_seen = sample_tick && armed && last_smp && !sync_pin;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           last_smp <= 1'b1;
      else if (sample_tick) last_smp <= sync_pin;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  flag_q <= 1'b0;
      else if (mode == TRIG_LEVEL) flag_q <= 1'b0;
      else if (fall_seen)          flag_q <= 1'b1;
      else if (clr)                flag_q <= 1'b0;
   end

   always_comb begin
      unique case (mode)
         TRIG_FALL:  irq_req = flag_q;
         TRIG_LEVEL: irq_req = !last_smp;
         default:    irq_req = 1'b0;
      endcase
   end
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
   import ext_irq_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sample_tick,
   input  logic [NUM_PINS-1:0] pin_n,
   input  logic [NUM_PINS-1:0] edge_mode,
   input  logic [NUM_PINS-1:0] irq_en,
   input  logic [NUM_PINS-1:0] ack,
   input  logic [NUM_PINS-1:0] sw_clr,
   input  logic                low_power,
   output logic [NUM_PINS-1:0] irq_req,
   output logic                wake
);
   generate
      if (NUM_PINS < 1 || NUM_PINS > MAX_PINS) begin : g_bad_pins
         $error("ext_irq_detect: NUM_PINS out of range");
      end
      if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
         $error("ext_irq_detect: SYNC_STAGES too small");
      end
   endgenerate

   logic                armed;
   logic [NUM_PINS-1:0] sync_pin;

   ext_irq_arm #(.SETTLE(SYNC_STAGES)) u_arm (
      .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .armed(armed)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      ext_irq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
         .clk(clk), .rst_n(rst_n), .d(pin_n[i]), .q(sync_pin[i])
      );
      ext_irq_pin u_pin (
         .clk(clk), .rst_n(rst_n), .sync_pin(sync_pin[i]),
         .sample_tick(sample_tick), .armed(armed),
         .edge_mode(edge_mode[i]), .clr(ack[i] | sw_clr[i]),
         .irq_req(irq_req[i])
      );
   end

   assign wake = low_power && |(irq_req & irq_en);
endmodule

// File: rtl/ext_irq_detect_chk.sv
module ext_irq_detect_chk #(
   parameter int unsigned NUM_PINS = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sample_tick,
   input logic [NUM_PINS-1:0] pin_n,
   input logic [NUM_PINS-1:0] edge_mode,
   input logic [NUM_PINS-1:0] irq_en,
   input logic [NUM_PINS-1:0] ack,
   input logic [NUM_PINS-1:0] sw_clr,
   input logic                low_power,
   input logic [NUM_PINS-1:0] irq_req,
   input logic                wake
);
   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq_req == '0));

   assert_wake_needs_lp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> low_power);

   assert_wake_on_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (low_power && ((irq_req & irq_en) != '0)) |-> wake);

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
      assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_mode[i] && irq_req[i] && !ack[i] && !sw_clr[i])
         |=> (irq_req[i] || !edge_mode[i]));

      assert_no_set_without_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_mode[i] && !irq_req[i] && !sample_tick)
         |=> (!irq_req[i] || !edge_mode[i]));

      assert_level_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (!edge_mode[i] && $past(!edge_mode[i]) && !$past(sample_tick))
         |-> $stable(irq_req[i]));
   end
endmodule

bind ext_irq_detect ext_irq_detect_chk #(.NUM_PINS(NUM_PINS)) u_chk (.*);

// File: tb/ext_irq_detect_test.sv
`timescale 1ns/1ps
module ext_irq_detect_test;
   localparam int NP = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sample_tick = 1'b0;
   logic [NP-1:0] pin_n = '1;
   logic [NP-1:0] edge_mode = '1;
   logic [NP-1:0] irq_en = '0;
   logic [NP-1:0] ack = '0;
   logic [NP-1:0] sw_clr = '0;
   logic          low_power = 1'b0;
   logic [NP-1:0] irq_req;
   logic          wake;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   // bench model state
   logic [NP-1:0] m_s1, m_s2, m_smp, m_flag;
   int            m_cnt;
   bit            m_armed;

   always #4 clk = ~clk;

   ext_irq_detect #(.NUM_PINS(NP), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .pin_n(pin_n),
      .edge_mode(edge_mode), .irq_en(irq_en), .ack(ack), .sw_clr(sw_clr),
      .low_power(low_power), .irq_req(irq_req), .wake(wake)
   );

   function automatic logic [NP-1:0] exp_req();
      logic [NP-1:0] r;
      for (int i = 0; i < NP; i++) r[i] = edge_mode[i] ? m_flag[i] : ~m_smp[i];
      return r;
   endfunction

   function automatic logic exp_wake();
      return low_power && ((exp_req() & irq_en) != '0);
   endfunction

   task automatic model_reset();
      m_s1 = '1; m_s2 = '1; m_smp = '1; m_flag = '0; m_cnt = 0; m_armed = 0;
   endtask

   task automatic model_step();
      logic [NP-1:0] fall;
      bit            settled;
      settled = (m_cnt >= 2);
      for (int i = 0; i < NP; i++) begin
         fall[i] = sample_tick && m_armed && m_smp[i] && !m_s2[i];
         if (!edge_mode[i])              m_flag[i] = 1'b0;
         else if (fall[i])               m_flag[i] = 1'b1;
         else if (ack[i] || sw_clr[i])   m_flag[i] = 1'b0;
      end
      if (sample_tick) m_smp = m_s2;
      if (settled && sample_tick) m_armed = 1;
      m_s2 = m_s1;
      m_s1 = pin_n;
      if (!settled) m_cnt++;
   endtask

   task automatic chk(string tag, logic [NP-1:0] act, logic [NP-1:0] expv);
      n_checks++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, expv, $time);
      end
   endtask

   task automatic cycle(string tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk(tag, irq_req, exp_req());
      chk("R8", {{(NP-1){1'b0}}, wake}, {{(NP-1){1'b0}}, exp_wake()});
      ack = '0;
      sw_clr = '0;
   endtask

   task automatic cycles(int n, string tag);
      for (int k = 0; k < n; k++) cycle(tag);
   endtask

   task automatic do_reset(logic [NP-1:0] pins);
      rst_n = 1'b0; pin_n = pins;
      repeat (3) @(negedge clk);
      model_reset();
      rst_n = 1'b1;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5EED_1D5));
      // R1: reset state with pins high
      edge_mode = 2'b11;
      do_reset('1);
      @(negedge clk);
      chk("R1", irq_req, 2'b00);
      chk("R1", {1'b0, wake}, 2'b00);

      // R7: pin0 held low through reset, ticks every cycle, edge mode
      do_reset(2'b10);
      sample_tick = 1'b1;
      cycles(8, "R7");
      chk("R7", irq_req, 2'b00);
      // R3: pin0 high then low -> edge request
      pin_n[0] = 1'b1; cycles(4, "R3");
      pin_n[0] = 1'b0; cycles(4, "R3");
      chk("R3", irq_req, 2'b01);
      // R10: pin1 unaffected
      chk("R10", {1'b0, irq_req[1]}, 2'b00);
      // R4: pin returns high, flag stays
      pin_n[0] = 1'b1; cycles(5, "R4");
      chk("R4", irq_req, 2'b01);
      // R8: wake with enable in low power
      low_power = 1'b1; irq_en = 2'b01;
      @(negedge clk); chk("R8", {1'b0, wake}, 2'b01);
      irq_en = 2'b10;
      @(negedge clk); chk("R8", {1'b0, wake}, 2'b00);
      low_power = 1'b0; irq_en = '0;
      // R5: acknowledge clears
      ack = 2'b01; cycle("R5");
      chk("R5", irq_req, 2'b00);
      // R5: software clear clears
      pin_n[0] = 1'b0; cycles(4, "R3");
      chk("R3", irq_req, 2'b01);
      sw_clr = 2'b01; cycle("R5");
      chk("R5", irq_req, 2'b00);

      // R6: falling sample and acknowledge on the same edge
      sample_tick = 1'b0;
      pin_n[0] = 1'b1; cycles(3, "R6");
      sample_tick = 1'b1; cycle("R6");
      sample_tick = 1'b0;
      pin_n[0] = 1'b0; cycles(3, "R6");
      chk("R6", irq_req, 2'b00);
      sample_tick = 1'b1; ack = 2'b01; cycle("R6");
      sample_tick = 1'b0;
      chk("R6", irq_req, 2'b01);
      sw_clr = 2'b01; cycle("R5");

      // R9: low pulse on pin1 that no tick sees
      pin_n[1] = 1'b0; cycles(4, "R9");
      pin_n[1] = 1'b1; cycles(4, "R9");
      sample_tick = 1'b1; cycles(3, "R9");
      chk("R9", irq_req, 2'b00);

      // R2: level mode follows sample, old flag discarded
      pin_n[1] = 1'b0; cycles(4, "R3");
      chk("R3", irq_req, 2'b10);
      edge_mode = 2'b00; pin_n = 2'b11; cycles(4, "R2");
      chk("R2", irq_req, 2'b00);
      edge_mode = 2'b10; cycle("R2");
      chk("R2", irq_req, 2'b00);
      edge_mode = 2'b00; pin_n = 2'b01; cycles(4, "R2");
      chk("R2", irq_req, 2'b10);

      // random phase, R10 per-pin independence checked against the model
      for (int n = 0; n < 4000; n++) begin
         sample_tick = ($urandom_range(0, 2) == 0);
         if ($urandom_range(0, 5) == 0) pin_n[$urandom_range(0, NP-1)] ^= 1'b1;
         if ($urandom_range(0, 60) == 0) edge_mode = NP'($urandom);
         irq_en    = NP'($urandom);
         low_power = $urandom_range(0, 1);
         ack       = ($urandom_range(0, 7) == 0) ? NP'($urandom) : '0;
         sw_clr    = ($urandom_range(0, 11) == 0) ? NP'($urandom) : '0;
         cycle(edge_mode != '0 ? "R10" : "R2");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule